// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a target on a two-wire serial bus (I2C) that sits in front of a small byte-addressed storage array. It samples the clock and data lines with the system clock and recognises the bus START and STOP conditions. After a START it compares the first byte with a fixed type code and three strapped address pins. When these match, it acknowledges the byte and then runs either a write or a read.

A write carries a two-byte word address followed by any number of data bytes. Each data byte is stored and the address then advances. A read returns bytes from the current address and keeps going while the bus controller acknowledges. It stops when the controller gives a NACK. Setting an address with a write and then issuing a repeated START with a read select gives a random read.

The block drives the data line only through `sda_oe`, which pulls SDA low when high. The line is open-drain with an external pull-up.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset `sda_oe` is low. Bus activity that is not preceded by a START never asserts `sda_oe`.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A STOP sends the block back to idle from any state, so later bytes are not acknowledged until a new START.
- R3: The select byte is bits 7..4 = 1010, bits 3..1 = {a2,a1,a0}, and bit 0 = direction (1 read, 0 write). A matching select byte is acknowledged: SDA is held low during the ninth SCL pulse.
- R4: A select byte whose type code or address bits differ is not acknowledged. The bytes that follow are ignored until the next START.
- R5: In a write, the two bytes after the select byte form the word address, high byte first. Address bits above the array width are ignored. Every byte of the write is acknowledged.
- R6: Each write data byte is stored at the current address, and the address then increments by one. A read likewise increments the address after each byte it sends.
- R7: A read starts at the current internal address. The address wraps from the top of the array to zero.
- R8: In a read, a master ACK (low in the ninth pulse) makes the block send the next byte. A NACK (high) stops transmission, and `sda_oe` stays low until the next START or STOP.
- R9: A write select with a word address, followed by a repeated START and a read select, returns data starting at that word address.
- R10: `sda_oe` changes only while SCL is low. The one exception is the release forced by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| a2 | input | 1 | Strapped address pin, select bit 3 |
| a1 | input | 1 | Strapped address pin, select bit 2 |
| a0 | input | 1 | Strapped address pin, select bit 1 |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
The assertions assume that SCL stays high or low for several system clocks, so that each of its edges passes the two-flop synchronizer as a single event. They also assume that the controller changes SDA only while SCL is low, except when it makes a START or STOP. The bench keeps each SCL phase at sixteen system clocks and changes data halfway through the low phase. It issues a START or STOP only when the target has released the line. The open-drain wire is modelled as the AND of the controller's drive and the inverse of `sda_oe`.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadAddr;
    logic writeByte;
    logic incAddr;
    logic txLoad;
    logic txShift;
    logic oeAck;
    logic oeRel;
  } dpCtl_t;
endpackage

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [2:0] devPins,
  input  logic [7:0] rxByte,
  input  logic       sdaOe,
  output logic       sdaBit,
  output dpCtl_t     ctl
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} state_t;
  typedef enum logic [1:0] {K_DEV, K_AHI, K_ALO, K_DATA} kind_t;

  logic [1:0] sclSh, sdaSh;
  logic       sclQ, sdaQ, sclS, sdaS;
  logic       sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclSh <= 2'b11; sdaSh <= 2'b11; sclQ <= 1'b1; sdaQ <= 1'b1;
    end else begin
      sclSh <= {sclSh[0], scl};
      sdaSh <= {sdaSh[0], sdaIn};
      sclQ  <= sclSh[1];
      sdaQ  <= sdaSh[1];
    end
  end

  assign sclS     = sclSh[1];
  assign sdaS     = sdaSh[1];
  assign sdaBit   = sdaS;
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

  state_t     state, stN;
  kind_t      kind, kindN;
  logic [3:0] bitCnt, cntN;
  logic       goRead, goReadN, mAck, mAckN;

  always_comb begin
    stN = state; kindN = kind; cntN = bitCnt; goReadN = goRead; mAckN = mAck;
    ctl = '0;
    if (stopDet) begin
      stN = S_IDLE; ctl.oeRel = 1'b1;
    end else if (startDet) begin
      stN = S_RX; kindN = K_DEV; cntN = 4'd0; ctl.oeRel = 1'b1;
    end else begin
      unique case (state)
        S_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            ctl.shiftIn = 1'b1; cntN = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            unique case (kind)
              K_DEV: begin
                if (rxByte[7:4] == TYPE_CODE && rxByte[3:1] == devPins) begin
                  ctl.oeAck = 1'b1; stN = S_ACK; goReadN = rxByte[0]; kindN = K_AHI;
                end else begin
                  stN = S_IDLE;
                end
              end
              K_AHI: begin
                ctl.oeAck = 1'b1; ctl.loadHi = 1'b1; stN = S_ACK; kindN = K_ALO;
              end
              K_ALO: begin
                ctl.oeAck = 1'b1; ctl.loadAddr = 1'b1; stN = S_ACK; kindN = K_DATA;
              end
              K_DATA: begin
                ctl.oeAck = 1'b1; ctl.writeByte = 1'b1; ctl.incAddr = 1'b1; stN = S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (sclFall) begin
            cntN = 4'd0;
            if (goRead) begin
              ctl.txLoad = 1'b1; stN = S_TX;
            end else begin
              ctl.oeRel = 1'b1; stN = S_RX;
            end
          end
        end
        S_TX: begin
          if (sclRise) cntN = bitCnt + 4'd1;
          else if (sclFall) begin
            if (bitCnt < 4'd8) ctl.txShift = 1'b1;
            else begin
              ctl.oeRel = 1'b1; ctl.incAddr = 1'b1; stN = S_MACK;
            end
          end
        end
        S_MACK: begin
          if (sclRise) mAckN = ~sdaS;
          else if (sclFall) begin
            if (mAck) begin
              ctl.txLoad = 1'b1; cntN = 4'd0; stN = S_TX;
            end else begin
              stN = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_DEV; bitCnt <= 4'd0; goRead <= 1'b0; mAck <= 1'b0;
    end else begin
      state <= stN; kind <= kindN; bitCnt <= cntN; goRead <= goReadN; mAck <= mAckN;
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sdaOe);
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stopDet |=> (state == S_IDLE));
  a_r8_nack_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK && sclFall && !mAck) |=> (state == S_IDLE && !sdaOe));
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sdaOe != $past(sdaOe)) |-> (!$past(sclS) || $past(startDet) || $past(stopDet)));
endmodule

// File: rtl/i2cmem_dp.sv
module i2cmem_dp
  import i2cmem_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dpCtl_t     ctl,
  input  logic       sdaBit,
  output logic [7:0] rxByte,
  output logic       sdaOe
);
  logic [7:0]    rxSh, hiByte, txSh;
  logic [AW-1:0] addr;
  logic [7:0]    mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxSh <= '0; hiByte <= '0; txSh <= '0; addr <= '0; sdaOe <= 1'b0;
    end else begin
      if (ctl.shiftIn) rxSh <= {rxSh[6:0], sdaBit};
      if (ctl.loadHi) hiByte <= rxSh;
      if (ctl.loadAddr) addr <= AW'({hiByte, rxSh});
      else if (ctl.incAddr) addr <= addr + 1'b1;
      if (ctl.txLoad) begin
        txSh  <= mem[addr];
        sdaOe <= ~mem[addr][7];
      end else if (ctl.txShift) begin
        txSh  <= {txSh[6:0], 1'b0};
        sdaOe <= ~txSh[6];
      end else if (ctl.oeAck) sdaOe <= 1'b1;
      else if (ctl.oeRel) sdaOe <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.writeByte) mem[addr] <= rxSh;
  end

  assign rxByte = rxSh;

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctl.loadAddr) && addr != $past(addr)) |-> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2cmem_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda_in,
  input  logic a2,
  input  logic a1,
  input  logic a0,
  output logic sda_oe
);
  localparam int AW = $clog2(DEPTH);

  dpCtl_t     ctl;
  logic       sdaBit;
  logic [7:0] rxByte;

  i2cmem_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sdaIn(sda_in),
    .devPins({a2, a1, a0}), .rxByte(rxByte), .sdaOe(sda_oe),
    .sdaBit(sdaBit), .ctl(ctl)
  );

  i2cmem_dp #(.DEPTH(DEPTH), .AW(AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .sdaBit(sdaBit),
    .rxByte(rxByte), .sdaOe(sda_oe)
  );
endmodule

// File: tb/i2c_mem_target_tb.sv
module i2c_mem_target_tb;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [2:0] pins = 3'b101;
  logic sda_oe;
  wire  sdaBus = sdaM & ~sda_oe;

  int checks = 0, failures = 0;
  int r10Viol = 0, oeSeen = 0;
  logic prevOe = 1'b0;

  always #2.5 clk = ~clk;

  i2c_mem_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl(sclM), .sda_in(sdaBus),
    .a2(pins[2]), .a1(pins[1]), .a0(pins[0]), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    if (sda_oe !== prevOe && sclM) r10Viol++;
    if (sda_oe) oeSeen++;
    prevOe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; w(H/2); sclM = 1'b1; w(H); sdaM = 1'b0; w(H); sclM = 1'b0; w(H/2);
  endtask

  task automatic busStop;
    sdaM = 1'b0; w(H/2); sclM = 1'b1; w(H); sdaM = 1'b1; w(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; w(H/2); sclM = 1'b1; w(H); sclM = 1'b0; w(H/2);
    end
    sdaM = 1'b1; w(H/2); sclM = 1'b1; w(H/2);
    acked = (sdaBus == 1'b0);
    w(H/2); sclM = 1'b0; w(H/2);
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H/2); sclM = 1'b1; w(H/2); b[i] = sdaBus; w(H/2); sclM = 1'b0;
    end
    w(H/2); sdaM = nack; w(H/2); sclM = 1'b1; w(H); sclM = 1'b0; w(H/2); sdaM = 1'b1;
  endtask

  function automatic logic [7:0] sel(input bit rd);
    return {4'b1010, pins, rd};
  endfunction

  task automatic setAddr(input logic [7:0] hi, input logic [7:0] lo);
    bit a;
    busStart;
    sendByte(sel(1'b0), a); chk(a, "R3 write select ack", a, 1);
    sendByte(hi, a);        chk(a, "R5 addr high ack", a, 1);
    sendByte(lo, a);        chk(a, "R5 addr low ack", a, 1);
  endtask

  task automatic testReset;
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
  endtask

  task automatic testNoStart;
    bit a;
    sclM = 1'b0; w(H/2);
    oeSeen = 0;
    sendByte(sel(1'b0), a);
    chk(!a, "R1 no ack without START", a, 0);
    chk(oeSeen == 0, "R1 sda_oe idle without START", oeSeen, 0);
    busStop;
  endtask

  task automatic testWrite;
    bit a;
    setAddr(8'hF3, 8'h10);
    sendByte(8'hC3, a); chk(a, "R5 data ack 0", a, 1);
    sendByte(8'h5E, a); chk(a, "R5 data ack 1", a, 1);
    sendByte(8'h81, a); chk(a, "R6 data ack 2", a, 1);
    busStop;
  endtask

  task automatic testRandomRead;
    bit a;
    logic [7:0] d;
    setAddr(8'h03, 8'h10);
    busStart;
    sendByte(sel(1'b1), a); chk(a, "R9 read select ack", a, 1);
    recvByte(1'b0, d); chk(d == 8'hC3, "R9 R5 first random byte", d, 8'hC3);
    recvByte(1'b0, d); chk(d == 8'h5E, "R6 second byte", d, 8'h5E);
    recvByte(1'b1, d); chk(d == 8'h81, "R6 third byte", d, 8'h81);
    oeSeen = 0;
    sdaM = 1'b1;
    for (int i = 0; i < 9; i++) begin
      w(H/2); sclM = 1'b1; w(H); sclM = 1'b0; w(H/2);
    end
    chk(oeSeen == 0, "R8 released after NACK", oeSeen, 0);
    busStop;
  endtask

  task automatic testWrap;
    bit a;
    logic [7:0] d;
    setAddr(8'h03, 8'hFF);
    sendByte(8'h11, a); chk(a, "R7 data ack", a, 1);
    sendByte(8'h22, a); chk(a, "R7 data ack wrap", a, 1);
    sendByte(8'h33, a); chk(a, "R7 data ack after wrap", a, 1);
    busStop;
    setAddr(8'h03, 8'hFF);
    busStart;
    sendByte(sel(1'b1), a); chk(a, "R3 read select ack", a, 1);
    recvByte(1'b0, d); chk(d == 8'h11, "R7 top byte", d, 8'h11);
    recvByte(1'b1, d); chk(d == 8'h22, "R7 wrapped byte", d, 8'h22);
    busStop;
    busStart;
    sendByte(sel(1'b1), a); chk(a, "R7 current read ack", a, 1);
    recvByte(1'b1, d); chk(d == 8'h33, "R7 current address read", d, 8'h33);
    busStop;
  endtask

  task automatic testMismatch;
    bit a;
    busStart;
    sendByte({4'b1010, pins ^ 3'b001, 1'b0}, a); chk(!a, "R4 pin mismatch nack", a, 0);
    sendByte(8'h00, a); chk(!a, "R4 following byte ignored", a, 0);
    busStop;
    busStart;
    sendByte({4'b1011, pins, 1'b0}, a); chk(!a, "R4 type code mismatch nack", a, 0);
    busStop;
    pins = 3'b010;
    w(H);
    busStart;
    sendByte(sel(1'b0), a); chk(a, "R4 R3 new pins match", a, 1);
    busStop;
  endtask

  task automatic testStop;
    bit a;
    logic [7:0] d;
    busStart;
    sendByte(sel(1'b0), a); chk(a, "R3 select before stop", a, 1);
    sendByte(8'h01, a);     chk(a, "R5 high before stop", a, 1);
    busStop;
    sclM = 1'b0; w(H/2);
    sendByte(8'h00, a); chk(!a, "R2 idle after STOP", a, 0);
    busStop;
    setAddr(8'h01, 8'h00);
    sendByte(8'h77, a); chk(a, "R6 data ack", a, 1);
    busStop;
    setAddr(8'h01, 8'h00);
    busStart;
    sendByte(sel(1'b1), a); chk(a, "R9 read select", a, 1);
    recvByte(1'b1, d); chk(d == 8'h77, "R2 R9 data after stop", d, 8'h77);
    busStop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    w(5);
    testReset;
    rst_n = 1'b1;
    w(H);
    testReset;
    testNoStart;
    testWrite;
    testRandomRead;
    testWrap;
    testMismatch;
    testStop;
    chk(r10Viol == 0, "R10 sda_oe changes with SCL low", r10Viol, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule